// File: doc/BRIEF.md
# Sector Erase Accumulation Window Timer

This block sits on the device side of a NOR flash command decoder. It tracks the short acceptance period that follows a sector-erase command. During that period more sector-erase commands may arrive, and each one adds its sector to a selection mask. When the period runs out with no further sector command, the erase begins. The acceptance period runs again from its full length each time a sector is added. A status flag in the style of the DQ3 bit goes from 0 to 1 when the period closes.

The command decoder feeds the block one strobe per decoded command. Each strobe carries a command kind and a sector index. Once the erase has begun, every command except erase suspend is dropped, and each dropped command is flagged. A chip-erase command does not use the timer at all: it selects every sector and starts the erase at once. The erase engine reports completion on a done input, and the block then returns to idle. The array operation itself is not part of this block.

Top module: `erase_window_ctrl`

## Requirements
- R1: After synchronous reset, `sector_mask` is all zeros, `window_closed` is 0, and `erase_start` and `cmd_ignored` are 0.
- R2: Command kinds are encoded as 0 = sector erase, 1 = chip erase, 2 = erase suspend and 3 = other. In idle, a sector-erase strobe opens the window. From the next clock, bit i of `sector_mask` is set for sector index i, and `window_closed` stays 0 while the window is open.
- R3: Each sector-erase strobe inside the open window sets its bit and restarts the full window. The window closes exactly WINDOW_CYCLES clocks after the last accepted sector-erase strobe.
- R4: When the window expires, `window_closed` rises to 1. `erase_start` is high for exactly one clock, in the same cycle that `window_closed` rises.
- R5: While erasing, every strobe whose kind is not erase suspend is dropped. Each dropped strobe raises `cmd_ignored` for one clock on the next cycle, and `sector_mask` does not change.
- R6: Erase suspend is never flagged as ignored. Inside an open window it neither restarts nor stops the timer and leaves the mask unchanged.
- R7: A chip-erase strobe in idle bypasses the window. On the next clock every mask bit is set, `window_closed` is 1 and `erase_start` pulses.
- R8: A chip-erase or other strobe during an open window cancels the selection. The mask clears, `window_closed` stays 0, and no erase starts later.
- R9: While erasing, `erase_done` clears the mask, lowers `window_closed` and returns the block to idle on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_kind | input | 2 | Command kind (0 sector, 1 chip, 2 suspend, 3 other) |
| cmd_sector | input | SEC_W | Sector index that goes with a sector-erase command |
| erase_done | input | 1 | The erase engine has finished |
| sector_mask | output | NUM_SECTORS | Selected sectors |
| window_closed | output | 1 | 0 while the window is open or idle, 1 once the erase has begun |
| erase_start | output | 1 | One-clock pulse when the erase begins |
| cmd_ignored | output | 1 | One-clock pulse for each command dropped during the erase |

## Verification
A timer that failed to restart would raise `window_closed` too early. This shows within a few clocks of a second sector command, because the close cycle is counted from the last accepted strobe rather than the first. A sequencer stuck in the wrong state shows up on the next strobe. In that case sector commands would be flagged as ignored when they should be accepted, or accepted when they should be dropped. A cancel or done that failed to clear the selection leaves stray bits in `sector_mask`, which a population count sees on the very next clock.

// File: rtl/erase_win_pkg.sv
package erase_win_pkg;

    typedef enum logic [1:0] {
        CMD_SECTOR  = 2'd0,
        CMD_CHIP    = 2'd1,
        CMD_SUSPEND = 2'd2,
        CMD_OTHER   = 2'd3
    } cmd_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WINDOW  = 2'd1,
        ST_ERASING = 2'd2
    } win_state_e;

    typedef struct packed {
        logic set_en;
        logic clr_all;
        logic fill_all;
    } mask_ctl_t;

    function automatic logic is_kind(input logic [1:0] k, input cmd_kind_e ref_kind);
        return cmd_kind_e'(k) == ref_kind;
    endfunction

endpackage

// File: rtl/erase_win_timer.sv
module erase_win_timer #(
    parameter int WINDOW_CYCLES = 2500
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic expire
);
    localparam int CW = $clog2(WINDOW_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(WINDOW_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                       cnt <= '0;
        else if (restart)              cnt <= '0;
        else if (run && cnt != LIMIT)  cnt <= cnt + 1'b1;
    end

    assign expire = run && !restart && (cnt == LIMIT);

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIMIT);

    assert_restart_zero_R3: assert property (@(posedge clk) disable iff (rst)
        restart |=> cnt == '0);
endmodule

// File: rtl/erase_win_mask.sv
module erase_win_mask
    import erase_win_pkg::*;
#(
    parameter int NUM_SECTORS = 128,
    parameter int SEC_W       = $clog2(NUM_SECTORS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  mask_ctl_t              ctl,
    input  logic [SEC_W-1:0]       idx,
    output logic [NUM_SECTORS-1:0] mask
);
    for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || ctl.clr_all)                          mask[i] <= 1'b0;
            else if (ctl.fill_all)                           mask[i] <= 1'b1;
            else if (ctl.set_en && idx == SEC_W'(i))         mask[i] <= 1'b1;
        end
    end

    assert_no_shrink_R5: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clr_all) |=> ((mask & $past(mask)) == $past(mask)));
endmodule

// File: rtl/erase_win_fsm.sv
module erase_win_fsm
    import erase_win_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_kind,
    input  logic       erase_done,
    input  logic       expire,
    output win_state_e state,
    output logic       restart,
    output mask_ctl_t  mctl,
    output logic       window_closed,
    output logic       erase_start,
    output logic       cmd_ignored
);
    win_state_e nxt;
    logic       drop;

    always_comb begin
        nxt          = state;
        restart      = 1'b0;
        mctl         = '0;
        drop         = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid && is_kind(cmd_kind, CMD_SECTOR)) begin
                    nxt = ST_WINDOW; restart = 1'b1; mctl.set_en = 1'b1;
                end else if (cmd_valid && is_kind(cmd_kind, CMD_CHIP)) begin
                    nxt = ST_ERASING; mctl.fill_all = 1'b1;
                end
            end
            ST_WINDOW: begin
                if (cmd_valid && is_kind(cmd_kind, CMD_SECTOR)) begin
                    restart = 1'b1; mctl.set_en = 1'b1;
                end else if (cmd_valid && !is_kind(cmd_kind, CMD_SUSPEND)) begin
                    nxt = ST_IDLE; mctl.clr_all = 1'b1;
                end else if (expire) begin
                    nxt = ST_ERASING;
                end
            end
            ST_ERASING: begin
                drop = cmd_valid && !is_kind(cmd_kind, CMD_SUSPEND);
                if (erase_done) begin
                    nxt = ST_IDLE; mctl.clr_all = 1'b1;
                end
            end
            default: begin
                nxt = ST_IDLE; mctl.clr_all = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            window_closed <= 1'b0;
            erase_start   <= 1'b0;
            cmd_ignored   <= 1'b0;
        end else begin
            state         <= nxt;
            window_closed <= (nxt == ST_ERASING);
            erase_start   <= (state != ST_ERASING) && (nxt == ST_ERASING);
            cmd_ignored   <= drop;
        end
    end

    assert_start_single_R4: assert property (@(posedge clk) disable iff (rst)
        erase_start |=> !erase_start);

    assert_close_starts_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(window_closed) |-> erase_start);

    assert_ignore_only_erasing_R5: assert property (@(posedge clk) disable iff (rst)
        cmd_ignored |-> $past(state == ST_ERASING));

    assert_suspend_not_dropped_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && is_kind(cmd_kind, CMD_SUSPEND)) |=> !cmd_ignored);

    assert_done_lowers_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ERASING && erase_done) |=> !window_closed);
endmodule

// File: rtl/erase_window_ctrl.sv
module erase_window_ctrl
    import erase_win_pkg::*;
#(
    parameter int NUM_SECTORS   = 128,
    parameter int WINDOW_CYCLES = 2500,
    parameter int SEC_W         = $clog2(NUM_SECTORS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmd_valid,
    input  logic [1:0]             cmd_kind,
    input  logic [SEC_W-1:0]       cmd_sector,
    input  logic                   erase_done,
    output logic [NUM_SECTORS-1:0] sector_mask,
    output logic                   window_closed,
    output logic                   erase_start,
    output logic                   cmd_ignored
);
    win_state_e state;
    logic       restart;
    logic       expire;
    mask_ctl_t  mctl;

    erase_win_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .cmd_valid     (cmd_valid),
        .cmd_kind      (cmd_kind),
        .erase_done    (erase_done),
        .expire        (expire),
        .state         (state),
        .restart       (restart),
        .mctl          (mctl),
        .window_closed (window_closed),
        .erase_start   (erase_start),
        .cmd_ignored   (cmd_ignored)
    );

    erase_win_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (state == ST_WINDOW),
        .restart (restart),
        .expire  (expire)
    );

    erase_win_mask #(.NUM_SECTORS(NUM_SECTORS), .SEC_W(SEC_W)) u_mask (
        .clk  (clk),
        .rst  (rst),
        .ctl  (mctl),
        .idx  (cmd_sector),
        .mask (sector_mask)
    );

    assert_idle_empty_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (sector_mask == '0));

    assert_window_open_low_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WINDOW) |-> !window_closed);
endmodule

// File: tb/erase_window_ctrl_tb_top.sv
module erase_window_ctrl_tb_top;
    localparam int NS   = 128;
    localparam int W    = 4;
    localparam int SW   = 7;
    localparam int NVEC = 29;

    logic          clk = 1'b0;
    logic          rst;
    logic          cmd_valid;
    logic [1:0]    cmd_kind;
    logic [SW-1:0] cmd_sector;
    logic          erase_done;
    logic [NS-1:0] sector_mask;
    logic          window_closed, erase_start, cmd_ignored;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    erase_window_ctrl #(.NUM_SECTORS(NS), .WINDOW_CYCLES(W)) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_sector(cmd_sector), .erase_done(erase_done),
        .sector_mask(sector_mask), .window_closed(window_closed),
        .erase_start(erase_start), .cmd_ignored(cmd_ignored)
    );

    // {valid, kind, sector, done, exp_closed, exp_start, exp_ign, exp_popcount}
    localparam logic [21:0] VEC [NVEC] = '{
        {1'b1, 2'd0, 7'd5,  1'b0, 1'b0, 1'b0, 1'b0, 8'd1},   // R2 open
        {1'b0, 2'd0, 7'd0,  1'b0, 1'b0, 1'b0, 1'b0, 8'd1},
        {1'b1, 2'd0, 7'd9,  1'b0, 1'b0, 1'b0, 1'b0, 8'd2},   // R3 restart
        {1'b0, 2'd0, 7'd0,  1'b0, 1'b0, 1'b0, 1'b0, 8'd2},
        {1'b0, 2'd0, 7'd0,  1'b0, 1'b0, 1'b0, 1'b0, 8'd2},   // R3 still open
        {1'b0, 2'd0, 7'd0,  1'b0, 1'b0, 1'b0, 1'b0, 8'd2},
        {1'b0, 2'd0, 7'd0,  1'b0, 1'b1, 1'b1, 1'b0, 8'd2},   // R4 expiry
        {1'b0, 2'd0, 7'd0,  1'b0, 1'b1, 1'b0, 1'b0, 8'd2},   // R4 one pulse
        {1'b1, 2'd0, 7'd20, 1'b0, 1'b1, 1'b0, 1'b1, 8'd2},   // R5 drop sector
        {1'b1, 2'd2, 7'd0,  1'b0, 1'b1, 1'b0, 1'b0, 8'd2},   // R6 suspend
        {1'b1, 2'd1, 7'd0,  1'b0, 1'b1, 1'b0, 1'b1, 8'd2},   // R5 drop chip
        {1'b1, 2'd3, 7'd0,  1'b0, 1'b1, 1'b0, 1'b1, 8'd2},   // R5 drop other
        {1'b0, 2'd0, 7'd0,  1'b1, 1'b0, 1'b0, 1'b0, 8'd0},   // R9 done
        {1'b1, 2'd0, 7'd3,  1'b0, 1'b0, 1'b0, 1'b0, 8'd1},   // R2
        {1'b1, 2'd3, 7'd0,  1'b0, 1'b0, 1'b0, 1'b0, 8'd0},   // R8 cancel
        {1'b0, 2'd0, 7'd0,  1'b0, 1'b0, 1'b0, 1'b0, 8'd0},
        {1'b0, 2'd0, 7'd0,  1'b0, 1'b0, 1'b0, 1'b0, 8'd0},
        {1'b0, 2'd0, 7'd0,  1'b0, 1'b0, 1'b0, 1'b0, 8'd0},
        {1'b0, 2'd0, 7'd0,  1'b0, 1'b0, 1'b0, 1'b0, 8'd0},   // R8 no late start
        {1'b1, 2'd1, 7'd0,  1'b0, 1'b1, 1'b1, 1'b0, 8'd128}, // R7 chip bypass
        {1'b0, 2'd0, 7'd0,  1'b0, 1'b1, 1'b0, 1'b0, 8'd128},
        {1'b1, 2'd0, 7'd1,  1'b0, 1'b1, 1'b0, 1'b1, 8'd128}, // R5
        {1'b0, 2'd0, 7'd0,  1'b1, 1'b0, 1'b0, 1'b0, 8'd0},   // R9
        {1'b1, 2'd0, 7'd7,  1'b0, 1'b0, 1'b0, 1'b0, 8'd1},
        {1'b1, 2'd2, 7'd0,  1'b0, 1'b0, 1'b0, 1'b0, 8'd1},   // R6 suspend in window
        {1'b0, 2'd0, 7'd0,  1'b0, 1'b0, 1'b0, 1'b0, 8'd1},
        {1'b0, 2'd0, 7'd0,  1'b0, 1'b0, 1'b0, 1'b0, 8'd1},
        {1'b0, 2'd0, 7'd0,  1'b0, 1'b1, 1'b1, 1'b0, 8'd1},   // R6 timer kept running
        {1'b0, 2'd0, 7'd0,  1'b1, 1'b0, 1'b0, 1'b0, 8'd0}    // R9
    };

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] k, input logic [SW-1:0] s, input logic d);
        @(negedge clk);
        cmd_valid = v; cmd_kind = k; cmd_sector = s; erase_done = d;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_kind = 2'd0; cmd_sector = '0; erase_done = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        check("R1 mask",    128'(sector_mask), 128'd0);
        check("R1 closed",  128'(window_closed), 128'd0);
        check("R1 pulses",  128'({erase_start, cmd_ignored}), 128'd0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            logic [21:0] v;
            v = VEC[i];
            drive(v[21], v[20:19], v[18:12], v[11]);
            check($sformatf("vec%0d closed R2/R3/R4", i), 128'(window_closed), 128'(v[10]));
            check($sformatf("vec%0d start R4", i),        128'(erase_start),   128'(v[9]));
            check($sformatf("vec%0d ignored R5", i),      128'(cmd_ignored),   128'(v[8]));
            check($sformatf("vec%0d popcount R5/R8", i),  128'($countones(sector_mask)), 128'(v[7:0]));
        end

        // R2: bit positions at both ends of the sector range
        drive(1'b1, 2'd0, 7'd0, 1'b0);
        drive(1'b1, 2'd0, 7'd127, 1'b0);
        check("R2 edge bits", 128'(sector_mask), (128'd1 << 127) | 128'd1);
        drive(1'b1, 2'd0, 7'd127, 1'b0);
        check("R3 repeat same sector", 128'(sector_mask), (128'd1 << 127) | 128'd1);
        for (int j = 0; j < W - 1; j++) drive(1'b0, 2'd0, 7'd0, 1'b0);
        check("R3 open before limit", 128'(window_closed), 128'd0);
        drive(1'b0, 2'd0, 7'd0, 1'b0);
        check("R3 closes at limit", 128'(window_closed), 128'd1);
        check("R4 start with close", 128'(erase_start), 128'd1);
        drive(1'b0, 2'd0, 7'd0, 1'b1);
        check("R9 mask cleared", 128'(sector_mask), 128'd0);

        // R8: chip erase inside window cancels
        drive(1'b1, 2'd0, 7'd40, 1'b0);
        drive(1'b1, 2'd1, 7'd0, 1'b0);
        check("R8 chip cancels mask", 128'(sector_mask), 128'd0);
        check("R8 chip cancels start", 128'({window_closed, erase_start}), 128'd0);

        // R1: reset in mid-erase
        drive(1'b1, 2'd1, 7'd0, 1'b0);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #2;
        check("R1 reset mid erase", 128'({window_closed, sector_mask}), 128'd0);
        @(negedge clk); rst = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule